// File: doc/BRIEF.md
# Six-Master Bus Arbiter with Slot Limit

This block decides which of six bus masters owns a single shared slave port. Each master raises a request line, marks whether its current burst has an undefined length, and pulses a per-beat completion strobe. The block answers with a registered one-hot grant vector. Configuration inputs pick between a strict priority order and a rotating order. They also pick how the bus is parked while nobody requests: on nobody, on the previous owner or on a chosen master. A further input sets a cycle budget that caps how long one owner may keep the bus once others are waiting.

The grant only moves at a beat boundary, when the owner pulses its completion strobe, or when the bus is idle or the owner has withdrawn its request. A master running an undefined-length burst keeps the bus across beat boundaries until its budget runs out. When the budget is spent and another master is waiting, the owner is skipped at the next beat boundary. When nobody else is waiting, the owner keeps the bus and its budget starts again.

Top module: `slot_burst_arbiter`

## Requirements
- R1: At most one bit of `grantOut` is set in any cycle.
- R2: With `cfgRoundRobin`=0, an arbitration grants the lowest-numbered eligible requester (master 0 ranks first, master 5 last).
- R3: With `cfgRoundRobin`=1, an arbitration grants the first eligible requester found when scanning upward from the master after the most recently granted requester, wrapping from 5 to 0. After reset the most recent requester counts as master 5.
- R4: An arbitration happens on a clock edge only when the grant is empty, or the owner is not requesting, or the owner pulses `doneIn` (subject to R5). Otherwise `grantOut` keeps its value.
- R5: When the owner pulses `doneIn` while its `undefBurstIn` bit is 1 and its budget is not spent, it keeps the grant.
- R6: The budget reloads from `cfgSlotLimit` on every arbitration and then drops by one per held cycle down to zero. It is spent when it is zero and `cfgSlotLimit` is non-zero. An owner whose budget is spent loses the grant at its next `doneIn` if any other master requests.
- R7: When the budget is spent and no other master requests, the owner's `doneIn` re-grants the same owner.
- R8: With `cfgSlotLimit`=0 the budget is never spent, so an undefined-length burst is never broken.
- R9: With no requests and `cfgParkMode`=0 (or 3), `grantOut` becomes all zero one cycle later.
- R10: With no requests and `cfgParkMode`=1, the grant parks on the most recently granted requester (master 5 after reset).
- R11: With no requests and `cfgParkMode`=2, the grant parks on master `cfgParkIdx`, or on nobody if that index is 6 or 7.
- R12: During reset `grantOut` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | 6 | Request line per master |
| doneIn | input | 6 | Per-master strobe marking the last cycle of a beat |
| undefBurstIn | input | 6 | Per-master flag: current burst has undefined length |
| cfgRoundRobin | input | 1 | 0 = fixed priority, 1 = rotating priority |
| cfgParkMode | input | 2 | Idle parking: 0 none, 1 last owner, 2 fixed index, 3 none |
| cfgParkIdx | input | 3 | Master to park on in mode 2 |
| cfgSlotLimit | input | 8 | Cycle budget per grant, 0 = unlimited |
| grantOut | output | 6 | Registered one-hot grant |

## Verification
The embedded properties assume that the request, completion and burst-type lines are sampled only as a set on the rising edge. They also assume that a completion strobe from a master that does not own the bus carries no meaning, so the checks only look at the strobe bit under the current grant. The stimulus changes configuration only at phase boundaries between long random runs, drives completion strobes on every master at random, and toggles request bits a few at a time, so owners both withdraw and stay. Directed runs cover the zero budget, a lone requester with an expired budget, and parking indices beyond the master count.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    PARK_NONE  = 2'd0,
    PARK_LAST  = 2'd1,
    PARK_FIXED = 2'd2,
    PARK_RSVD  = 2'd3
  } parkMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic arbitrate;     // load a new grant this edge
    logic excludeOwner;  // drop the current owner from the candidates
  } ctrlStrobe_t;

endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
#(
  parameter int N       = 6,
  parameter int LIMIT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [N-1:0]       reqIn,
  input  logic [N-1:0]       doneIn,
  input  logic [N-1:0]       undefIn,
  input  logic [N-1:0]       grantIn,
  input  logic [LIMIT_W-1:0] cfgSlotLimit,
  output ctrlStrobe_t        strobe
);

  logic               ownerReq;
  logic               ownerDone;
  logic               ownerUndef;
  logic               othersReq;
  logic               busIdle;
  logic               expired;
  logic [LIMIT_W-1:0] slotLeft;

  assign ownerReq   = |(reqIn & grantIn);
  assign ownerDone  = |(doneIn & grantIn);
  assign ownerUndef = |(undefIn & grantIn);
  assign othersReq  = |(reqIn & ~grantIn);
  assign busIdle    = (grantIn == '0);
  assign expired    = (cfgSlotLimit != '0) && (slotLeft == '0);

  always_comb begin
    strobe.arbitrate    = busIdle || !ownerReq ||
                          (ownerDone && (!ownerUndef || expired));
    strobe.excludeOwner = expired && othersReq;
  end

  // Slot budget: reload on every arbitration, count down while held
  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotLeft <= '0;
    end else if (strobe.arbitrate) begin
      slotLeft <= cfgSlotLimit;
    end else if (slotLeft != '0) begin
      slotLeft <= slotLeft - 1'b1;
    end
  end

  AST_UNDEF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ownerReq && ownerDone && ownerUndef && !expired) |=> $stable(grantIn)); // R5

  AST_SLOT_BREAK: assert property (@(posedge clk) disable iff (!rstN)
    (ownerReq && ownerDone && expired && othersReq) |=> ((grantIn & $past(grantIn)) == '0)); // R6

  AST_LONE_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (ownerReq && ownerDone && expired && !othersReq) |=> $stable(grantIn)); // R7

endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int N     = 6,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N-1:0]     reqIn,
  input  ctrlStrobe_t      strobe,
  input  logic             cfgRoundRobin,
  input  logic [1:0]       cfgParkMode,
  input  logic [IDX_W-1:0] cfgParkIdx,
  output logic [N-1:0]     grantQ
);

  logic [IDX_W-1:0] lastIdx;
  logic [N-1:0]     candMask;
  logic [N-1:0]     fixedPick;
  logic [N-1:0]     rotatePick;
  logic [N-1:0]     parkGrant;
  logic [N-1:0]     nextGrant;

  function automatic logic [N-1:0] pickLowest(input logic [N-1:0] m);
    logic [N-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (m[IDX_W'(i)]) begin
        r = '0;
        r[IDX_W'(i)] = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic [N-1:0] pickAfter(input logic [N-1:0] m,
                                              input logic [IDX_W-1:0] from);
    logic [N-1:0] r;
    logic         hit;
    int           sum;
    r   = '0;
    hit = 1'b0;
    for (int k = 1; k <= N; k++) begin
      sum = int'(from) + k;
      if (sum >= N) sum = sum - N;
      if (!hit && m[IDX_W'(sum)]) begin
        r[IDX_W'(sum)] = 1'b1;
        hit            = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] toIdx(input logic [N-1:0] oh);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++) begin
      if (oh[IDX_W'(i)]) r = IDX_W'(i);
    end
    return r;
  endfunction

  // Per-master eligibility
  for (genvar g = 0; g < N; g++) begin : gen_cand
    assign candMask[g] = reqIn[g] & ~(strobe.excludeOwner & grantQ[g]);
  end

  assign fixedPick  = pickLowest(candMask);
  assign rotatePick = pickAfter(candMask, lastIdx);

  always_comb begin
    parkGrant = '0;
    case (parkMode_e'(cfgParkMode))
      PARK_LAST:  parkGrant[lastIdx] = 1'b1;
      PARK_FIXED: if (int'(cfgParkIdx) < N) parkGrant[cfgParkIdx] = 1'b1;
      default:    parkGrant = '0;
    endcase
  end

  always_comb begin
    if (candMask == '0)      nextGrant = parkGrant;
    else if (cfgRoundRobin)  nextGrant = rotatePick;
    else                     nextGrant = fixedPick;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantQ  <= '0;
      lastIdx <= IDX_W'(N - 1);
    end else if (strobe.arbitrate) begin
      grantQ <= nextGrant;
      if (candMask != '0) lastIdx <= toIdx(nextGrant);
    end
  end

  AST_FIXED_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.arbitrate && !cfgRoundRobin && candMask[0]) |=> grantQ[0]); // R2

endmodule

// File: rtl/slot_burst_arbiter.sv
module slot_burst_arbiter
  import arb_pkg::*;
#(
  parameter  int NUM_MASTERS = 6,
  parameter  int LIMIT_W     = 8,
  localparam int IDX_W       = $clog2(NUM_MASTERS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_MASTERS-1:0] reqIn,
  input  logic [NUM_MASTERS-1:0] doneIn,
  input  logic [NUM_MASTERS-1:0] undefBurstIn,
  input  logic                   cfgRoundRobin,
  input  logic [1:0]             cfgParkMode,
  input  logic [IDX_W-1:0]       cfgParkIdx,
  input  logic [LIMIT_W-1:0]     cfgSlotLimit,
  output logic [NUM_MASTERS-1:0] grantOut
);

  ctrlStrobe_t            strobe;
  logic [NUM_MASTERS-1:0] grantQ;

  arb_ctrl #(.N(NUM_MASTERS), .LIMIT_W(LIMIT_W)) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .reqIn        (reqIn),
    .doneIn       (doneIn),
    .undefIn      (undefBurstIn),
    .grantIn      (grantQ),
    .cfgSlotLimit (cfgSlotLimit),
    .strobe       (strobe)
  );

  arb_datapath #(.N(NUM_MASTERS), .IDX_W(IDX_W)) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .reqIn         (reqIn),
    .strobe        (strobe),
    .cfgRoundRobin (cfgRoundRobin),
    .cfgParkMode   (cfgParkMode),
    .cfgParkIdx    (cfgParkIdx),
    .grantQ        (grantQ)
  );

  assign grantOut = grantQ;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantOut)); // R1

  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ((|(grantOut & reqIn)) && !(|(grantOut & doneIn))) |=> $stable(grantOut)); // R4

  AST_PARK_NONE: assert property (@(posedge clk) disable iff (!rstN)
    ((reqIn == '0) && (cfgParkMode == 2'd0 || cfgParkMode == 2'd3)) |=> (grantOut == '0)); // R9

  AST_PARK_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ((reqIn == '0) && (cfgParkMode == 2'd2) && (int'(cfgParkIdx) >= NUM_MASTERS))
      |=> (grantOut == '0)); // R11

endmodule

// File: tb/slot_burst_arbiter_tb_top.sv
module slot_burst_arbiter_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic [5:0] reqIn, doneIn, undefIn;
  logic       rr;
  logic [1:0] park;
  logic [2:0] parkIdx;
  logic [7:0] lim;
  logic [5:0] grantOut;

  always #4 clk = ~clk;  // 8 ns period

  slot_burst_arbiter dut_i (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .doneIn(doneIn),
    .undefBurstIn(undefIn), .cfgRoundRobin(rr), .cfgParkMode(park),
    .cfgParkIdx(parkIdx), .cfgSlotLimit(lim), .grantOut(grantOut)
  );

  int    tests = 0;
  int    fails = 0;
  bit    over  = 1'b0;
  logic [5:0] mGrant;
  int    mLast;
  int    mSlot;
  string expTag;

  task automatic check(input bit ok, input string tag,
                       input logic [5:0] act, input logic [5:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: grant actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] oneHot(input int i);
    return (i < 6) ? (6'b000001 << i) : 6'b000000;
  endfunction

  // Reference model built from the requirements
  task automatic modelStep();
    bit oReq, oDone, oUndef, spent, others, arb;
    logic [5:0] cand, nxt;
    int pick;
    oReq   = |(mGrant & reqIn);
    oDone  = |(mGrant & doneIn);
    oUndef = |(mGrant & undefIn);
    spent  = (lim != 0) && (mSlot == 0);
    others = |(reqIn & ~mGrant);
    arb    = (mGrant == 0) || !oReq || (oDone && (!oUndef || spent));
    if (!arb) begin
      expTag = (oDone && oUndef) ? ((lim == 0) ? "R8" : "R5") : "R4";
      if (mSlot > 0) mSlot--;
    end else begin
      cand = (spent && others) ? (reqIn & ~mGrant) : reqIn;
      if (cand == 0) begin
        case (park)
          2'd1:    begin nxt = oneHot(mLast);        expTag = "R10"; end
          2'd2:    begin nxt = oneHot(int'(parkIdx)); expTag = "R11"; end
          default: begin nxt = 6'b0;                 expTag = "R9";  end
        endcase
      end else begin
        pick = -1;
        if (rr) begin
          for (int k = 1; k <= 6; k++)
            if (pick < 0 && cand[(mLast + k) % 6]) pick = (mLast + k) % 6;
          expTag = "R3";
        end else begin
          for (int k = 0; k < 6; k++)
            if (pick < 0 && cand[k]) pick = k;
          expTag = "R2";
        end
        if (oReq && oDone && spent) expTag = others ? "R6" : "R7";
        nxt   = oneHot(pick);
        mLast = pick;
      end
      mGrant = nxt;
      mSlot  = int'(lim);
    end
  endtask

  task automatic step();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    check(grantOut === mGrant, expTag, grantOut, mGrant);
    check($countones(grantOut) <= 1, "R1", grantOut, mGrant);
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!over) begin
      tests++;
      fails++;
      $display("FAIL watchdog R4: actual hung run, expected completion");
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd7321));
    rstN = 1'b0; reqIn = 0; doneIn = 0; undefIn = 0;
    rr = 0; park = 0; parkIdx = 0; lim = 0;
    mGrant = 0; mLast = 5; mSlot = 0;
    repeat (3) @(negedge clk);
    reqIn = 6'b111111;
    @(negedge clk);
    check(grantOut == 6'b0, "R12", grantOut, 6'b0);  // R12 reset state
    reqIn = 0;
    rstN  = 1'b1;

    // R9: park on nobody
    park = 2'd0; step(); step();
    park = 2'd3; step();
    // R10: park on master 5 after reset, then on the last owner
    park = 2'd1; step(); step();
    reqIn = 6'b000100; step(); step();
    reqIn = 6'b000000; step();
    // R11: fixed index, then out-of-range index
    park = 2'd2; parkIdx = 3'd3; step();
    parkIdx = 3'd6; step();
    parkIdx = 3'd7; step();

    // R8: unlimited undefined burst on master 1, master 3 waiting
    rr = 0; lim = 0; undefIn = 6'b000010; doneIn = 6'b000010;
    reqIn = 6'b001010;
    repeat (30) step();
    // R6: budget now set; spent budget breaks the burst toward master 3
    lim = 8'd3;
    repeat (6) step();
    // R7: lone requester keeps the bus after its budget runs out
    reqIn = 6'b000010; doneIn = 6'b000010; undefIn = 6'b000000; lim = 8'd2;
    repeat (8) step();
    // R3: rotating order with everyone requesting
    rr = 1; lim = 0; undefIn = 0; reqIn = 6'b111111; doneIn = 6'b111111;
    repeat (12) step();

    // Random phases
    for (int ph = 0; ph < 24; ph++) begin
      rr      = 1'($urandom % 2);
      park    = 2'($urandom % 4);
      parkIdx = 3'($urandom % 8);
      case ($urandom % 5)
        0: lim = 8'd0;
        1: lim = 8'd1;
        2: lim = 8'd2;
        3: lim = 8'd3;
        default: lim = 8'd6;
      endcase
      undefIn = 6'($urandom);
      for (int c = 0; c < 300; c++) begin
        reqIn  = reqIn ^ (6'($urandom) & 6'($urandom));
        if ($urandom % 16 == 0) reqIn = 6'b0;
        doneIn = 6'($urandom);
        step();
      end
    end

    over = 1'b1;
    finishRun();
  end

endmodule